// File: doc/BRIEF.md
# Two-Channel Interrupt Factor Controller

This block sits between a two-channel I2C master core and a CPU. Each channel raises three kinds of event: a command that has completed or failed, a receive data step and a transmit data step. The block latches these events as factor flags and gates them with per-factor enable bits. It then picks the most urgent channel using a 3-bit level per channel and asks the CPU for an interrupt only when the CPU would accept it. Software reaches the flags, the enables and the levels through a small register bus. Flags are cleared by writing 1s.

A data step becomes a DMA request factor only when the channel is in DMA mode and its transfer command names the matching direction. Each such request also fires a one-cycle trigger toward an intelligent DMA unit, together with that unit's channel number.

Top module: `irqf_ctrl_top`

## Requirements
- R1: After a synchronous reset, the flag, enable and level registers read 0, and `irq_req`, `irq_level`, `irq_chan` and `idma_trig` are 0.
- R2: A `cmd_done` pulse on channel c sets flag bit 3c, whatever the enable bits hold. The flag layout is bit 3c+0 complete/error, bit 3c+1 read DMA and bit 3c+2 write DMA. The enable register uses the same layout.
- R3: A `data_strobe` pulse on channel c sets flag bit 3c+1 only when `dma_mode[c]` is 1 and the 3-bit command `xfer_cmd[3c+2:3c]` equals 3'b011 (receive). In every other case it sets no read flag.
- R4: A `data_strobe` pulse on channel c sets flag bit 3c+2 only when `dma_mode[c]` is 1 and the command equals 3'b100 (transmit).
- R5: Writing to address 0 clears every flag bit written as 1 and leaves the other flags unchanged. When a set event and a clear hit the same bit in the same cycle, the bit ends at 1.
- R6: A channel competes only if one of its flags is 1 and the matching enable bit is also 1, and its level is not 0. Level 0 masks the channel.
- R7: Among the channels that compete, the one with the highest level wins. `irq_level` and `irq_chan` show the winner one cycle after the register state changes. On equal levels, channel 0 wins. With no competitor, both read 0.
- R8: `irq_req` is 1 only when a winner exists, `cpu_ie` is 1 and `cpu_il` is strictly below the winner's level. It updates one cycle after its inputs.
- R9: In the cycle after a read or write DMA factor fires, `idma_trig` pulses for one cycle. `idma_ch` then carries 0x36 for channel 0 read, 0x37 for channel 0 write, 0x38 for channel 1 read or 0x39 for channel 1 write. When both channels fire in the same cycle, channel 0's number is sent.
- R10: The register map is: address 0 flags in bits [5:0], address 1 enables in bits [5:0], address 2 levels with channel 0 in bits [2:0] and channel 1 in bits [6:4]. Unused bits read 0. Read data appears on `bus_rdata` one cycle after the read cycle and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cmd_done | input | 2 | Per-channel command complete/error pulse |
| data_strobe | input | 2 | Per-channel data step pulse |
| dma_mode | input | 2 | Per-channel DMA mode set up |
| xfer_cmd | input | 6 | Per-channel 3-bit transfer command |
| cpu_ie | input | 1 | CPU interrupt enable |
| cpu_il | input | 3 | CPU current interrupt level |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 3 | Level of the winning channel |
| irq_chan | output | 1 | Index of the winning channel |
| idma_trig | output | 1 | One-cycle DMA trigger |
| idma_ch | output | 8 | DMA channel number for the trigger |

## Verification
The assertions assume that event pulses on `cmd_done` and `data_strobe` are single-cycle and synchronous to `clk`. They also assume that `cpu_ie` and `cpu_il` stay stable around the edge that registers the request. The bench drives every input on the falling edge and holds each event for exactly one cycle. It changes the CPU inputs only between checks and waits two edges before it samples the request outputs.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  // factors per channel and their slot inside a channel's group
  localparam int FPC    = 3;
  localparam int F_DONE = 0;
  localparam int F_RD   = 1;
  localparam int F_WR   = 2;
  localparam int CMD_W  = 3;
  localparam logic [CMD_W-1:0] CMD_RX = 3'b011;
  localparam logic [CMD_W-1:0] CMD_TX = 3'b100;
  // register addresses
  localparam int ADDR_FLAG = 0;
  localparam int ADDR_EN   = 1;
  localparam int ADDR_PRIO = 2;
endpackage

// File: rtl/irqf_factor_detect.sv
module irqf_factor_detect
  import irqf_pkg::*;
(
  input  logic             done_evt,
  input  logic             step_evt,
  input  logic             dma_on,
  input  logic [CMD_W-1:0] cmd,
  output logic [FPC-1:0]   fire
);
  always_comb begin
    fire         = '0;
    fire[F_DONE] = done_evt;
    fire[F_RD]   = step_evt && dma_on && (cmd == CMD_RX);
    fire[F_WR]   = step_evt && dma_on && (cmd == CMD_TX);
  end
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
  import irqf_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int AW  = 2,
  parameter int LW  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  input  logic [NCH*FPC-1:0]      set_vec,
  output logic [NCH*FPC-1:0]      flags,
  output logic [NCH*FPC-1:0]      enables,
  output logic [NCH-1:0][LW-1:0]  prio
);
  localparam int NF     = NCH * FPC;
  localparam int STRIDE = LW + 1;

  logic          wr_flag, wr_en, wr_prio, rd_any;
  logic [NF-1:0] clr_mask;
  logic [DW-1:0] rmux;

  assign wr_flag  = bus_sel && bus_wr && (bus_addr == AW'(ADDR_FLAG));
  assign wr_en    = bus_sel && bus_wr && (bus_addr == AW'(ADDR_EN));
  assign wr_prio  = bus_sel && bus_wr && (bus_addr == AW'(ADDR_PRIO));
  assign rd_any   = bus_sel && !bus_wr;
  assign clr_mask = wr_flag ? bus_wdata[NF-1:0] : '0;

  always_comb begin
    rmux = '0;
    case (bus_addr)
      AW'(ADDR_FLAG): rmux[NF-1:0] = flags;
      AW'(ADDR_EN):   rmux[NF-1:0] = enables;
      AW'(ADDR_PRIO): begin
        for (int c = 0; c < NCH; c++) rmux[c*STRIDE +: LW] = prio[c];
      end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      enables   <= '0;
      prio      <= '0;
      bus_rdata <= '0;
    end else begin
      flags     <= (flags & ~clr_mask) | set_vec;
      if (wr_en) enables <= bus_wdata[NF-1:0];
      if (wr_prio) begin
        for (int c = 0; c < NCH; c++) prio[c] <= bus_wdata[c*STRIDE +: LW];
      end
      bus_rdata <= rd_any ? rmux : '0;
    end
  end

  // R2: any fired factor is held in its flag on the next cycle
  p_set_latches_r2: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R5: bits written 1 with no concurrent set read 0 afterwards
  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
    wr_flag |=> ((flags & $past(bus_wdata[NF-1:0] & ~set_vec)) == '0));

  // R10: read data is zero when no read took place
  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> (bus_rdata == '0));
endmodule

// File: rtl/irqf_arbiter.sv
module irqf_arbiter
  import irqf_pkg::*;
#(
  parameter int NCH = 2,
  parameter int LW  = 3,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH*FPC-1:0]      flags,
  input  logic [NCH*FPC-1:0]      enables,
  input  logic [NCH-1:0][LW-1:0]  prio,
  input  logic                    cpu_ie,
  input  logic [LW-1:0]           cpu_il,
  output logic                    irq_req,
  output logic [LW-1:0]           irq_level,
  output logic [CW-1:0]           irq_chan
);
  logic [NCH-1:0] pend;
  logic           found;
  logic [LW-1:0]  best_lvl;
  logic [CW-1:0]  best_ch;

  for (genvar c = 0; c < NCH; c++) begin : g_pend
    assign pend[c] = (|(flags[c*FPC +: FPC] & enables[c*FPC +: FPC]))
                     && (prio[c] != '0);
  end

  // ascending scan, strict compare: lower index keeps a tie
  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_ch  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (pend[c] && (!found || prio[c] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = prio[c];
        best_ch  = CW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
      irq_chan  <= '0;
    end else begin
      irq_req   <= found && cpu_ie && (cpu_il < best_lvl);
      irq_level <= best_lvl;
      irq_chan  <= best_ch;
    end
  end

  // R8: a request implies the CPU had interrupts on
  p_req_needs_ie_r8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(cpu_ie));

  // R8: a request level is strictly above the CPU level
  p_req_above_il_r8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_level > $past(cpu_il)));

  // R6: a request needs an enabled pending flag
  p_req_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(flags & enables) != '0));
endmodule

// File: rtl/irqf_ctrl_top.sv
module irqf_ctrl_top
  import irqf_pkg::*;
#(
  parameter int           NCH       = 2,
  parameter int           DW        = 8,
  parameter int           AW        = 2,
  parameter int           LW        = 3,
  parameter int           IW        = 8,
  parameter logic [IW-1:0] IDMA_BASE = 8'h36
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NCH-1:0]       cmd_done,
  input  logic [NCH-1:0]       data_strobe,
  input  logic [NCH-1:0]       dma_mode,
  input  logic [NCH*CMD_W-1:0] xfer_cmd,
  input  logic                 cpu_ie,
  input  logic [LW-1:0]        cpu_il,
  output logic                 irq_req,
  output logic [LW-1:0]        irq_level,
  output logic                 irq_chan,
  output logic                 idma_trig,
  output logic [IW-1:0]        idma_ch
);
  localparam int NF = NCH * FPC;

  logic [NCH-1:0][FPC-1:0] fire;
  logic [NF-1:0]           set_vec, flags_q, en_q;
  logic [NCH-1:0][LW-1:0]  prio_q;
  logic                    trig_n;
  logic [IW-1:0]           ch_n, trig_off;

  for (genvar c = 0; c < NCH; c++) begin : g_det
    irqf_factor_detect u_det (
      .done_evt (cmd_done[c]),
      .step_evt (data_strobe[c]),
      .dma_on   (dma_mode[c]),
      .cmd      (xfer_cmd[c*CMD_W +: CMD_W]),
      .fire     (fire[c])
    );
  end

  assign set_vec = fire;

  irqf_regs #(.NCH(NCH), .DW(DW), .AW(AW), .LW(LW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .set_vec   (set_vec),
    .flags     (flags_q),
    .enables   (en_q),
    .prio      (prio_q)
  );

  irqf_arbiter #(.NCH(NCH), .LW(LW), .CW(1)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags_q),
    .enables   (en_q),
    .prio      (prio_q),
    .cpu_ie    (cpu_ie),
    .cpu_il    (cpu_il),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .irq_chan  (irq_chan)
  );

  // descending scan so that channel 0 is written last and wins
  always_comb begin
    trig_n = 1'b0;
    ch_n   = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (fire[c][F_RD]) begin
        trig_n = 1'b1;
        ch_n   = IDMA_BASE + IW'(2 * c);
      end else if (fire[c][F_WR]) begin
        trig_n = 1'b1;
        ch_n   = IDMA_BASE + IW'(2 * c + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idma_trig <= 1'b0;
      idma_ch   <= '0;
    end else begin
      idma_trig <= trig_n;
      idma_ch   <= trig_n ? ch_n : '0;
    end
  end

  assign trig_off = idma_ch - IDMA_BASE;

  // R9: a trigger carries a number inside the assigned range
  p_trig_range_r9: assert property (@(posedge clk) disable iff (rst)
    idma_trig |-> (trig_off < IW'(2 * NCH)));

  // R9: the factor named by a trigger is flagged in the same cycle
  p_trig_flagged_r9: assert property (@(posedge clk) disable iff (rst)
    idma_trig |-> flags_q[(int'(trig_off) / 2) * FPC + 1 + (int'(trig_off) % 2)]);
endmodule

// File: tb/test_irqf_ctrl_top.sv
`timescale 1ns/1ps
module test_irqf_ctrl_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [1:0] cmd_done, data_strobe, dma_mode;
  logic [5:0] xfer_cmd;
  logic       cpu_ie;
  logic [2:0] cpu_il;
  logic       irq_req, irq_chan, idma_trig;
  logic [2:0] irq_level;
  logic [7:0] idma_ch;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irqf_ctrl_top i_irqf_ctrl_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_done(cmd_done), .data_strobe(data_strobe), .dma_mode(dma_mode),
    .xfer_cmd(xfer_cmd), .cpu_ie(cpu_ie), .cpu_il(cpu_il),
    .irq_req(irq_req), .irq_level(irq_level), .irq_chan(irq_chan),
    .idma_trig(idma_trig), .idma_ch(idma_ch)
  );

  // vector: [0]done [1]strobe [2]dma [5:3]cmd [6]chan [13:8]flags
  //         [23:16]dma number [24]trigger
  localparam logic [31:0] VEC [9] = '{
    32'h00000101, 32'h00000841, 32'h0136021E, 32'h01370426, 32'h0000001A,
    32'h00000016, 32'h0138105E, 32'h01392066, 32'h0000005C
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_events();
    cmd_done = '0; data_strobe = '0; dma_mode = '0; xfer_cmd = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    clear_events(); cpu_ie = 0; cpu_il = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(2'd0, rd); check("R1 flags", rd, 0);
    bus_read(2'd1, rd); check("R1 enables", rd, 0);
    bus_read(2'd2, rd); check("R1 levels", rd, 0);
    check("R1 outputs", {irq_req, irq_level, irq_chan, idma_trig, idma_ch}, 0);

    // vector table: factor detection and trigger numbers
    for (int i = 0; i < 9; i++) begin
      logic [31:0] v;
      int c;
      v = VEC[i];
      c = int'(v[6]);
      bus_write(2'd0, 8'h3F);
      @(negedge clk);
      cmd_done[c] = v[0]; data_strobe[c] = v[1]; dma_mode[c] = v[2];
      xfer_cmd[c*3 +: 3] = v[5:3];
      @(negedge clk);
      clear_events();
      check("R9 trigger", {idma_trig, idma_ch}, {v[24], v[23:16]});
      bus_read(2'd0, rd);
      check("R2/R3/R4 flags", rd, {2'b00, v[13:8]});
    end

    // R9 both channels in one cycle: channel 0 number wins
    bus_write(2'd0, 8'h3F);
    @(negedge clk);
    data_strobe = 2'b11; dma_mode = 2'b11; xfer_cmd = {3'b100, 3'b011};
    @(negedge clk);
    clear_events();
    check("R9 simultaneous", {idma_trig, idma_ch}, {1'b1, 8'h36});
    @(negedge clk);
    check("R9 one-cycle pulse", idma_trig, 0);
    bus_read(2'd0, rd); check("R3/R4 both flags", rd, 8'h22);

    // R10 register map readback
    bus_write(2'd2, 8'hFF); bus_read(2'd2, rd); check("R10 level bits", rd, 8'h77);
    bus_write(2'd1, 8'hFF); bus_read(2'd1, rd); check("R10 enable bits", rd, 8'h3F);
    bus_write(2'd1, 8'h00); bus_write(2'd2, 8'h00);

    // R5 write-one-to-clear and set priority over clear
    bus_write(2'd0, 8'h3F);
    bus_read(2'd0, rd); check("R5 cleared", rd, 0);
    @(negedge clk);
    cmd_done = 2'b01; bus_sel = 1; bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h01;
    @(negedge clk);
    clear_events(); bus_sel = 0; bus_wr = 0;
    bus_read(2'd0, rd); check("R5 set wins", rd, 8'h01);
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, rd); check("R5 zero write keeps", rd, 8'h01);

    // R6 enable gating and level-zero mask
    cpu_ie = 1; cpu_il = 0;
    bus_write(2'd2, 8'h05); settle();
    check("R6 flag not enabled", {irq_req, irq_level}, 0);
    bus_write(2'd1, 8'h01); settle();
    check("R6 enabled", {irq_req, irq_level, irq_chan}, {1'b1, 3'd5, 1'b0});
    bus_write(2'd2, 8'h00); settle();
    check("R6 level zero masks", {irq_req, irq_level}, 0);

    // R8 CPU acceptance
    bus_write(2'd2, 8'h05);
    cpu_ie = 0; settle(); check("R8 ie off", irq_req, 0);
    cpu_ie = 1; cpu_il = 3'd5; settle(); check("R8 il equal", irq_req, 0);
    cpu_il = 3'd4; settle(); check("R8 il below", irq_req, 1);

    // R7 priority between channels
    cpu_il = 0;
    @(negedge clk); cmd_done = 2'b10; @(negedge clk); clear_events();
    bus_write(2'd1, 8'h09);
    bus_write(2'd2, 8'h53); settle();
    check("R7 ch1 higher", {irq_req, irq_level, irq_chan}, {1'b1, 3'd5, 1'b1});
    bus_write(2'd2, 8'h55); settle();
    check("R7 tie ch0", {irq_req, irq_level, irq_chan}, {1'b1, 3'd5, 1'b0});
    bus_write(2'd2, 8'h36); settle();
    check("R7 ch0 higher", {irq_req, irq_level, irq_chan}, {1'b1, 3'd6, 1'b0});
    bus_write(2'd1, 8'h01); bus_write(2'd2, 8'h53); settle();
    check("R7 ch1 not enabled", {irq_req, irq_level, irq_chan}, {1'b1, 3'd3, 1'b0});
    bus_write(2'd0, 8'h3F); settle();
    check("R7 none pending", {irq_req, irq_level, irq_chan}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule